// File: doc/BRIEF.md
# Idle-Gap Command Receive Buffer

This block collects command bytes from an asynchronous spacecraft link into one of two equal banks. Each byte arrives with a one-cycle valid strobe; UART bit recovery happens upstream. A command has no length field and no delimiter. Its end is found when the line has stayed quiet for a programmable number of clock cycles. At that point the block closes the bank being filled, records its byte count and error flags, and moves on to the other bank so that the next command never has to wait.

The processor learns that a bank was closed from a one-cycle done pulse, which also tells it the bank index. It picks a bank with a select input. Through that select it reads back the bank's bytes, its count and its flags with a combinational lookup. When it has finished with the bank it gives a release pulse. The link sends commands tens of milliseconds apart and the gap is a couple of milliseconds, so software normally has a whole command period to drain one bank. If it falls behind, the block still switches, and it marks the overwritten bank so software can see the damage.

Top module: `cmd_gap_buffer`

## Requirements
- R1: After reset, bank 0 is the fill bank, neither bank is ready, `done_o` and `overrun_o` are low, and the stored count of both banks reads 0.
- R2: Received bytes are stored at addresses 0, 1, 2, ... of the fill bank in arrival order. Once that bank is closed they read back unchanged through `rd_bank_i`/`rd_addr_i`.
- R3: If the fill bank holds at least one byte and no byte is accepted for GAP_CYCLES consecutive clock edges after the last accepted one, `done_o` pulses for one cycle, appearing exactly GAP_CYCLES edges after the last byte's edge. `done_bank_o` then gives the closed bank, and the other bank becomes the fill bank.
- R4: Every accepted byte restarts the idle count. Bytes spaced fewer than GAP_CYCLES edges apart end up in one bank.
- R5: An empty fill bank is never closed, however long the line stays idle.
- R6: When a bank closes, `stat_count_o` for that bank reports the number of bytes stored, up to DEPTH. Bytes beyond DEPTH are discarded, and `stat_ovf_o` reads 1 for that bank; otherwise it reads 0.
- R7: `bank_ready_o[b]` goes to 1 when bank b closes. A `release_i` pulse clears the bit of the bank selected by `rd_bank_i`. Releasing a bank that is not ready has no effect.
- R8: If the block switches into a bank that is still ready (not released), `overrun_o` pulses in the same cycle as `done_o`. That bank's ready bit clears, and its `stat_ovr_o` reads 1 once it is closed again; a bank entered after a release reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid_i | input | 1 | One-cycle strobe: `rx_data_i` holds a received byte |
| rx_data_i | input | 8 | Received byte |
| rd_bank_i | input | 1 | Bank selected for data, status and release |
| rd_addr_i | input | $clog2(DEPTH) | Byte address within the selected bank |
| rd_data_o | output | 8 | Byte at `rd_addr_i` of the selected bank (combinational) |
| stat_count_o | output | $clog2(DEPTH+1) | Stored byte count of the selected bank |
| stat_ovf_o | output | 1 | Selected bank received more than DEPTH bytes |
| stat_ovr_o | output | 1 | Selected bank was entered before it had been released |
| release_i | input | 1 | One-cycle pulse releasing the selected bank |
| bank_ready_o | output | 2 | Per-bank closed-and-not-released flags |
| done_o | output | 1 | One-cycle pulse: a bank has just closed |
| done_bank_o | output | 1 | Index of the bank most recently closed |
| overrun_o | output | 1 | One-cycle pulse: switched into an unreleased bank |

## Verification
A wrong idle count shows at the ports as a done pulse one or more cycles early or late, or as a command split in two or merged with the next. The bench times each pulse to the exact edge against the last byte, so such an error is caught at the first closure. A fill pointer or bank index that goes astray shows up as a wrong count, a wrong bank number or wrong read-back bytes when the affected bank closes. A ready or overrun flag with the wrong value appears at the next closure, through a missing or spurious overrun pulse or a wrong overwrite flag, and at the latest one command later.

// File: rtl/cgb_pkg.sv
`timescale 1ns/1ps
package cgb_pkg;
  localparam int unsigned CGB_NBANK = 2;

  typedef struct packed {
    logic ovf;  // more bytes than bank depth arrived
    logic ovr;  // bank was entered while still unreleased
  } cgb_flags_t;
endpackage

// File: rtl/cgb_rst_sync.sv
`timescale 1ns/1ps
module cgb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cgb_gap_timer.sv
`timescale 1ns/1ps
module cgb_gap_timer #(
  parameter int unsigned GAP_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_i,
  input  logic armed_i,
  output logic expire_o
);
  localparam int unsigned GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  logic [GW-1:0] cnt_q, cnt_d;
  logic          hit;

  assign hit      = (cnt_q == GW'(GAP_CYCLES - 1));
  assign expire_o = armed_i && !byte_i && hit;

  always_comb begin
    if (byte_i || !armed_i || hit) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cgb_bank_mem.sv
`timescale 1ns/1ps
module cgb_bank_mem #(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic                     wbank_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [7:0]               wdata_i,
  input  logic                     rbank_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [7:0]               rdata_o
);
  logic [7:0] bank_rd [cgb_pkg::CGB_NBANK];

  for (genvar gb = 0; gb < cgb_pkg::CGB_NBANK; gb++) begin : g_bank
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == 1'(gb))) store[waddr_i] <= wdata_i;
    end

    assign bank_rd[gb] = store[raddr_i];
  end

  assign rdata_o = bank_rd[rbank_i];
endmodule

// File: rtl/cgb_bank_ctrl.sv
`timescale 1ns/1ps
module cgb_bank_ctrl
  import cgb_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       byte_i,
  input  logic                       expire_i,
  input  logic                       release_i,
  input  logic                       sel_bank_i,
  output logic                       wr_en_o,
  output logic                       wr_bank_o,
  output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_cnt_o,
  output logic                       done_o,
  output logic                       done_bank_o,
  output logic                       overrun_o,
  output logic [CGB_NBANK-1:0]       ready_o,
  output logic [$clog2(DEPTH+1)-1:0] sel_cnt_o,
  output cgb_flags_t                 sel_flags_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic                 wr_bank_q, wr_bank_d;
  logic [CW-1:0]        fill_q, fill_d;
  cgb_flags_t           fflg_q, fflg_d;
  logic [CGB_NBANK-1:0] pend_q, pend_d;
  logic                 done_q, done_d;
  logic                 dbank_q, dbank_d;
  logic                 ovrun_q, ovrun_d;
  logic [CW-1:0]        scnt_q [CGB_NBANK];
  cgb_flags_t           sflg_q [CGB_NBANK];

  logic room, close, tgt, tgt_busy;

  assign room     = (fill_q < CW'(DEPTH));
  assign close    = expire_i && !byte_i;
  assign tgt      = ~wr_bank_q;
  assign tgt_busy = pend_q[tgt] && !(release_i && (sel_bank_i == tgt));

  // next-state logic
  always_comb begin
    wr_bank_d = wr_bank_q;
    fill_d    = fill_q;
    fflg_d    = fflg_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    dbank_d   = dbank_q;
    ovrun_d   = 1'b0;

    if (release_i) pend_d[sel_bank_i] = 1'b0;

    if (byte_i) begin
      if (room) fill_d     = fill_q + 1'b1;
      else      fflg_d.ovf = 1'b1;
    end else if (close) begin
      pend_d[wr_bank_q] = 1'b1;
      pend_d[tgt]       = 1'b0;
      wr_bank_d         = tgt;
      fill_d            = '0;
      fflg_d.ovf        = 1'b0;
      fflg_d.ovr        = tgt_busy;
      ovrun_d           = tgt_busy;
      done_d            = 1'b1;
      dbank_d           = wr_bank_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q <= 1'b0;
      fill_q    <= '0;
      fflg_q    <= '0;
      pend_q    <= '0;
      done_q    <= 1'b0;
      dbank_q   <= 1'b0;
      ovrun_q   <= 1'b0;
    end else begin
      wr_bank_q <= wr_bank_d;
      fill_q    <= fill_d;
      fflg_q    <= fflg_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
      dbank_q   <= dbank_d;
      ovrun_q   <= ovrun_d;
    end
  end

  // per-bank status capture, enabled on the closing edge of that bank
  for (genvar gb = 0; gb < CGB_NBANK; gb++) begin : g_stat
    logic cap_en;
    assign cap_en = close && (wr_bank_q == 1'(gb));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scnt_q[gb] <= '0;
        sflg_q[gb] <= '0;
      end else if (cap_en) begin
        scnt_q[gb] <= fill_q;
        sflg_q[gb] <= fflg_q;
      end
    end
  end

  assign wr_en_o     = byte_i && room;
  assign wr_bank_o   = wr_bank_q;
  assign wr_addr_o   = fill_q[AW-1:0];
  assign fill_cnt_o  = fill_q;
  assign done_o      = done_q;
  assign done_bank_o = dbank_q;
  assign overrun_o   = ovrun_q;
  assign ready_o     = pend_q;
  assign sel_cnt_o   = scnt_q[sel_bank_i];
  assign sel_flags_o = sflg_q[sel_bank_i];
endmodule

// File: rtl/cmd_gap_buffer.sv
`timescale 1ns/1ps
module cmd_gap_buffer
  import cgb_pkg::*;
#(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned GAP_CYCLES = 100000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rx_valid_i,
  input  logic [7:0]                 rx_data_i,
  input  logic                       rd_bank_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr_i,
  output logic [7:0]                 rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0] stat_count_o,
  output logic                       stat_ovf_o,
  output logic                       stat_ovr_o,
  input  logic                       release_i,
  output logic [CGB_NBANK-1:0]       bank_ready_o,
  output logic                       done_o,
  output logic                       done_bank_o,
  output logic                       overrun_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          rst_sync_n;
  logic          expire;
  logic          wr_en;
  logic          wr_bank;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] fill_cnt;
  cgb_flags_t    sel_flags;

  cgb_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cgb_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .byte_i   (rx_valid_i),
    .armed_i  (fill_cnt != '0),
    .expire_o (expire)
  );

  cgb_bank_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .byte_i      (rx_valid_i),
    .expire_i    (expire),
    .release_i   (release_i),
    .sel_bank_i  (rd_bank_i),
    .wr_en_o     (wr_en),
    .wr_bank_o   (wr_bank),
    .wr_addr_o   (wr_addr),
    .fill_cnt_o  (fill_cnt),
    .done_o      (done_o),
    .done_bank_o (done_bank_o),
    .overrun_o   (overrun_o),
    .ready_o     (bank_ready_o),
    .sel_cnt_o   (stat_count_o),
    .sel_flags_o (sel_flags)
  );

  cgb_bank_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .wbank_i (wr_bank),
    .waddr_i (wr_addr),
    .wdata_i (rx_data_i),
    .rbank_i (rd_bank_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign stat_ovf_o = sel_flags.ovf;
  assign stat_ovr_o = sel_flags.ovr;
endmodule

// File: rtl/cmd_gap_buffer_chk.sv
`timescale 1ns/1ps
module cmd_gap_buffer_chk #(
  parameter int unsigned DEPTH = 1024
) (
  input logic                       clk_i,
  input logic                       rst_n,
  input logic                       rx_valid_i,
  input logic                       done_o,
  input logic                       done_bank_o,
  input logic                       overrun_o,
  input logic [1:0]                 bank_ready_o,
  input logic                       wr_bank,
  input logic [$clog2(DEPTH+1)-1:0] fill_cnt
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  AST_FILL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R6

  AST_SWITCH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (done_bank_o == $past(wr_bank)) && (wr_bank != done_bank_o)); // R3

  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fill_cnt == '0) |=> !done_o); // R5

  AST_BYTE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_valid_i |=> !done_o); // R4

  AST_READY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> bank_ready_o[done_bank_o]); // R7

  AST_OVERRUN_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    overrun_o |-> done_o); // R8
endmodule

bind cmd_gap_buffer cmd_gap_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sync_n),
  .rx_valid_i   (rx_valid_i),
  .done_o       (done_o),
  .done_bank_o  (done_bank_o),
  .overrun_o    (overrun_o),
  .bank_ready_o (bank_ready_o),
  .wr_bank      (wr_bank),
  .fill_cnt     (fill_cnt)
);

// File: tb/cmd_gap_buffer_tb.sv
`timescale 1ns/1ps
module cmd_gap_buffer_tb;
  localparam int DEPTH = 1024;
  localparam int GAP   = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          rx_valid_i;
  logic [7:0]    rx_data_i;
  logic          rd_bank_i;
  logic [AW-1:0] rd_addr_i;
  logic [7:0]    rd_data_o;
  logic [CW-1:0] stat_count_o;
  logic          stat_ovf_o, stat_ovr_o;
  logic          release_i;
  logic [1:0]    bank_ready_o;
  logic          done_o, done_bank_o, overrun_o;

  cmd_gap_buffer #(.DEPTH(DEPTH), .GAP_CYCLES(GAP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rd_bank_i(rd_bank_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .stat_count_o(stat_count_o), .stat_ovf_o(stat_ovf_o), .stat_ovr_o(stat_ovr_o),
    .release_i(release_i), .bank_ready_o(bank_ready_o), .done_o(done_o),
    .done_bank_o(done_bank_o), .overrun_o(overrun_o)
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct { int cnt; int ovf; int last; } item_t;
  item_t      exp_q[$];
  logic [7:0] byte_q[$];

  int checks = 0, errors = 0, n_done = 0;
  bit auto_rel = 1'b1, mon_busy = 1'b0;
  bit mb = 1'b0, mfill_ovr = 1'b0;
  bit mpend [2] = '{1'b0, 1'b0};

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: sends one command and pushes its expected result
  task automatic send_msg(input int n, input int spacing, input logic [7:0] seed);
    item_t it;
    int    last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = seed + 8'(i);
      if (i < DEPTH) byte_q.push_back(seed + 8'(i));
      @(negedge clk_i);
      rx_valid_i = 1'b0;
      last = cyc;
      repeat (spacing) @(negedge clk_i);
    end
    it.cnt  = (n > DEPTH) ? DEPTH : n;
    it.ovf  = (n > DEPTH) ? 1 : 0;
    it.last = last;
    exp_q.push_back(it);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || mon_busy) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  // monitor: pops expectations as banks close
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        item_t it;
        bit    cb;
        int    bad;
        mon_busy = 1'b1;
        n_done++;
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R5 unexpected close: actual 1 expected 0");
        end else begin
          it = exp_q.pop_front();
          cb = mb;
          check("R3", "close cycle", cyc, it.last + GAP);
          check("R3", "closed bank", done_bank_o, cb);
          check("R8", "overrun pulse", overrun_o, mpend[~cb]);
          check("R7", "ready on close", bank_ready_o[cb], 1);
          rd_bank_i = cb;
          #1;
          check("R6", "byte count", stat_count_o, it.cnt);
          check("R6", "overflow flag", stat_ovf_o, it.ovf);
          check("R8", "overwrite flag", stat_ovr_o, mfill_ovr);
          mpend[cb] = 1'b1;
          mfill_ovr = mpend[~cb];
          mpend[~cb] = 1'b0;
          mb = ~cb;
          bad = 0;
          for (int i = 0; i < it.cnt; i++) begin
            logic [7:0] eb;
            eb = byte_q.pop_front();
            if (auto_rel) begin
              rd_addr_i = AW'(i);
              #1;
              if (rd_data_o !== eb) begin
                if (bad == 0)
                  $display("FAIL R2 byte %0d: actual %0d expected %0d", i, rd_data_o, eb);
                bad++;
              end
            end
          end
          if (auto_rel) begin
            checks++;
            if (bad != 0) errors++;
            @(negedge clk_i);
            release_i = 1'b1;
            @(negedge clk_i);
            release_i = 1'b0;
            mpend[cb] = 1'b0;
            #1;
            check("R7", "ready after release", bank_ready_o[cb], 0);
          end
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic run_all();
    rst_ni = 1'b0; rx_valid_i = 1'b0; rx_data_i = '0;
    rd_bank_i = 1'b0; rd_addr_i = '0; release_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "done", done_o, 0);
    check("R1", "overrun", overrun_o, 0);
    check("R1", "ready", bank_ready_o, 0);
    rd_bank_i = 1'b0; #1;
    check("R1", "bank0 count", stat_count_o, 0);
    rd_bank_i = 1'b1; #1;
    check("R1", "bank1 count", stat_count_o, 0);
    // R5 long idle with empty bank
    repeat (3 * GAP) @(negedge clk_i);
    check("R5", "closes while empty", n_done, 0);
    check("R5", "ready while empty", bank_ready_o, 0);
    // R2/R3 plain commands, R4 slow bytes, R6 overflow
    send_msg(5, 0, 8'h10);          wait_idle();
    send_msg(1, 0, 8'h40);          wait_idle();
    send_msg(4, GAP - 2, 8'h70);    wait_idle();  // R4 one bank despite slow bytes
    send_msg(DEPTH + 6, 0, 8'hA0);  wait_idle();  // R6 overflow
    // R8 software falls behind
    auto_rel = 1'b0;
    send_msg(3, 0, 8'h01); wait_idle();
    send_msg(2, 0, 8'h21); wait_idle();
    send_msg(4, 0, 8'h31); wait_idle();
    // R7 release both; bank 1 is not ready, so its release has no effect
    @(negedge clk_i); rd_bank_i = 1'b0; release_i = 1'b1;
    @(negedge clk_i); rd_bank_i = 1'b1;
    @(negedge clk_i); release_i = 1'b0;
    mpend[0] = 1'b0; mpend[1] = 1'b0;
    #1;
    check("R7", "ready after manual release", bank_ready_o, 0);
    auto_rel = 1'b1;
    send_msg(2, 0, 8'h55); wait_idle();
    check("R3", "total closes", n_done, 8);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule